// File: doc/BRIEF.md
# Permission-Checking Address Translation Buffer

This block is a small, fully associative buffer of page-table entries. It turns a 32-bit virtual address into a physical address in the cycle after the lookup. A virtual address has three fields. Bits 31..22 index the page directory, bits 21..12 index the page table, and bits 11..0 are the byte offset. Each slot keeps the virtual page number that filled it and a copy of the 32-bit entry in hardware format. The buffer enforces the entry's presence, write and user bits. An illegal access returns a fault with a cause code and no translation. A legal access sets the accessed status bit in the cached entry, and a legal write also sets the dirty bit.

A lookup that finds no slot reports a miss. The block then raises a refill request and holds the missing address until an external table walker delivers an entry. While that request is outstanding, no new lookup is accepted, and the requester issues the lookup again after the refill. Empty slots are filled first. Once every slot is in use, a free-running 16-bit LFSR picks the victim at random. Whenever a slot is evicted or invalidated, its page number and its accessed and dirty bits appear on a writeback port for one cycle, so they can be copied back into the page table.

The control is a two-state machine. `ST_IDLE` accepts lookups and invalidations. The transition `idle_to_fill` is taken on a lookup that misses, and it moves to `ST_FILL`. `ST_FILL` holds the refill request. The transition `fill_to_idle` is taken when `rf_valid` is seen, and it installs the entry.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `rf_req` and `wb_valid` are 0, `lk_ready` is 1, and every slot is empty, so the first lookup misses.
- R2: A lookup accepted at a clock edge produces `rsp_valid` for exactly one cycle after that edge. On a legal access to a 4 KiB entry, `rsp_hit`=1, `rsp_cause`=0 and `rsp_paddr` = {entry[31:12], vaddr[11:0]}.
- R3: A lookup that matches no slot responds with `rsp_hit`=0 and `rsp_fault`=0. From the next cycle, `rf_req`=1 and `rf_vaddr` holds the missing address, with `lk_ready`=0, until `rf_valid` is sampled. `rf_req` then drops.
- R4: A hit on an entry whose bit 0 (present) is 0 gives `rsp_fault`=1, `rsp_cause`=1 and `rsp_paddr`=0.
- R5: A write to an entry whose bit 1 (writable) is 0 gives cause 2. A user access (`lk_user`=1) to an entry whose bit 2 (user) is 0 gives cause 3. The priority is not-present, then user, then write. Supervisor accesses ignore bit 2.
- R6: A legal reference sets bit 5 (accessed) of the cached entry, and a legal write also sets bit 6 (dirty). A faulting access changes neither bit.
- R7: An entry with bit 7 (large) set matches on vaddr[31:22] alone and translates to {entry[31:22], vaddr[21:0]}.
- R8: An invalidate of page number `inv_vpn` that matches a slot empties it. In the next cycle, `wb_valid`=1 and the port carries that slot's page number and its accessed and dirty bits. An invalidate that matches nothing gives no writeback.
- R9: A refill writes into an empty slot when one exists, and then no writeback occurs. When all slots are in use, it evicts an LFSR-chosen slot and presents that slot's page number on the writeback port in the next cycle. The evicted page then misses.
- R10: While `inv_valid` is high, `lk_ready` is 0 and no lookup is accepted. While a refill is outstanding, invalidations are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Legal translation returned |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write-protect, 3 user-protect |
| rsp_paddr | output | 32 | Physical address (0 unless hit) |
| rf_req | output | 1 | Refill wanted for `rf_vaddr` |
| rf_vaddr | output | 32 | Held missing virtual address |
| rf_valid | input | 1 | Walker delivers an entry |
| rf_pte | input | 32 | Delivered page-table entry |
| inv_valid | input | 1 | Invalidate request |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| wb_valid | output | 1 | Writeback data valid |
| wb_vpn | output | 20 | Page number of the departing slot |
| wb_accessed | output | 1 | Its accessed bit |
| wb_dirty | output | 1 | Its dirty bit |

## Verification
The assertions check the following on every cycle:
- a response appears only after an accepted lookup, and never in the cycle after an invalidation;
- a fault never carries a hit, a zero cause or a non-zero address;
- a miss always raises the refill request, which then stays stable with the lookup port closed;
- a writeback follows only a refill or an invalidation.

The actual translations need the bench's scenarios. So do the cause priority, the large-page offset, the accessed and dirty state seen through the writeback port, the filling of empty slots before eviction, and the ignored invalidation during a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PTE_W     = 32;
    localparam int OFF_W     = 12;
    localparam int BIG_OFF_W = 22;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int DIR_W     = VA_W - BIG_OFF_W;

    localparam int B_PRESENT = 0;
    localparam int B_WRITE   = 1;
    localparam int B_USER    = 2;
    localparam int B_ACC     = 5;
    localparam int B_DIRTY   = 6;
    localparam int B_LARGE   = 7;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ABSENT  = 2'd1,
        CAUSE_WRPROT  = 2'd2,
        CAUSE_USRPROT = 2'd3
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } st_e;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam import tlb_pkg::*; #(
    parameter int ENTRIES = 8,
    parameter int IW      = 3
) (
    input  logic [ENTRIES-1:0]            ent_v,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_tag,
    input  logic [ENTRIES-1:0]            ent_large,
    input  logic [VPN_W-1:0]              vpn,
    output logic                          hit,
    output logic [IW-1:0]                 idx
);
    logic [ENTRIES-1:0] match_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_v[g] = ent_v[g] &&
            (ent_large[g] ? (ent_tag[g][VPN_W-1:VPN_W-DIR_W] == vpn[VPN_W-1:VPN_W-DIR_W])
                          : (ent_tag[g] == vpn));
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_v[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IW      = 3,
    parameter int RW      = 16
) (
    input  logic [ENTRIES-1:0] ent_v,
    input  logic [RW-1:0]      rnd,
    output logic [IW-1:0]      idx,
    output logic               evict
);
    logic [IW-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_v[i]) free_idx = IW'(i);
        end
        evict = &ent_v;
        idx   = evict ? IW'(rnd % RW'(ENTRIES)) : free_idx;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [31:0]       lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [31:0]       rsp_paddr,
    output logic              rf_req,
    output logic [31:0]       rf_vaddr,
    input  logic              rf_valid,
    input  logic [31:0]       rf_pte,
    input  logic              inv_valid,
    input  logic [19:0]       inv_vpn,
    output logic              wb_valid,
    output logic [19:0]       wb_vpn,
    output logic              wb_accessed,
    output logic              wb_dirty
);
    localparam int IW     = $clog2(ENTRIES);
    localparam int LFSR_W = 16;

    st_e state, state_nx;

    logic [ENTRIES-1:0]            ent_v;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
    logic [ENTRIES-1:0][PTE_W-1:0] ent_pte;
    logic [ENTRIES-1:0]            ent_large;

    logic              lk_match, inv_match, vic_evict;
    logic [IW-1:0]     lk_idx, inv_idx, vic_idx;
    logic [LFSR_W-1:0] lfsr_q;
    logic [PTE_W-1:0]  hit_pte;
    cause_e            cause;
    logic [VA_W-1:0]   xl_paddr;
    logic              lk_go, inv_go, fill_go;
    logic [VA_W-1:0]   miss_va;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_large
        assign ent_large[g] = ent_pte[g][B_LARGE];
    end

    tlb_cam #(.ENTRIES(ENTRIES), .IW(IW)) u_cam_lk (
        .ent_v(ent_v), .ent_tag(ent_tag), .ent_large(ent_large),
        .vpn(lk_vaddr[VA_W-1:OFF_W]), .hit(lk_match), .idx(lk_idx)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .IW(IW)) u_cam_inv (
        .ent_v(ent_v), .ent_tag(ent_tag), .ent_large(ent_large),
        .vpn(inv_vpn), .hit(inv_match), .idx(inv_idx)
    );

    tlb_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .q(lfsr_q));

    tlb_victim #(.ENTRIES(ENTRIES), .IW(IW), .RW(LFSR_W)) u_vic (
        .ent_v(ent_v), .rnd(lfsr_q), .idx(vic_idx), .evict(vic_evict)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        lk_ready = 1'b0;
        rf_req   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                lk_ready = !inv_valid;
                if (lk_valid && !inv_valid && !lk_match) state_nx = ST_FILL; // idle_to_fill
            end
            ST_FILL: begin
                rf_req = 1'b1;
                if (rf_valid) state_nx = ST_IDLE;                            // fill_to_idle
            end
        endcase
        lk_go   = lk_valid && lk_ready;
        inv_go  = inv_valid && (state == ST_IDLE) && inv_match;
        fill_go = rf_req && rf_valid;
    end

    // permission check and address formation
    always_comb begin
        hit_pte = ent_pte[lk_idx];
        if (!hit_pte[B_PRESENT])                cause = CAUSE_ABSENT;
        else if (lk_user && !hit_pte[B_USER])   cause = CAUSE_USRPROT;
        else if (lk_write && !hit_pte[B_WRITE]) cause = CAUSE_WRPROT;
        else                                    cause = CAUSE_NONE;
        xl_paddr = hit_pte[B_LARGE] ? {hit_pte[PTE_W-1:BIG_OFF_W], lk_vaddr[BIG_OFF_W-1:0]}
                                    : {hit_pte[PTE_W-1:OFF_W],     lk_vaddr[OFF_W-1:0]};
    end

    assign rf_vaddr = miss_va;

    // slots, response and writeback registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v       <= '0;
            ent_tag     <= '0;
            ent_pte     <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_cause   <= CAUSE_NONE;
            rsp_paddr   <= '0;
            wb_valid    <= 1'b0;
            wb_vpn      <= '0;
            wb_accessed <= 1'b0;
            wb_dirty    <= 1'b0;
            miss_va     <= '0;
        end else begin
            rsp_valid <= lk_go;
            wb_valid  <= 1'b0;
            if (lk_go) begin
                rsp_hit   <= lk_match && (cause == CAUSE_NONE);
                rsp_fault <= lk_match && (cause != CAUSE_NONE);
                rsp_cause <= lk_match ? cause : CAUSE_NONE;
                rsp_paddr <= (lk_match && cause == CAUSE_NONE) ? xl_paddr : '0;
                if (lk_match && cause == CAUSE_NONE) begin
                    ent_pte[lk_idx][B_ACC] <= 1'b1;
                    if (lk_write) ent_pte[lk_idx][B_DIRTY] <= 1'b1;
                end
                if (!lk_match) miss_va <= lk_vaddr;
            end
            if (inv_go) begin
                ent_v[inv_idx] <= 1'b0;
                wb_valid       <= 1'b1;
                wb_vpn         <= ent_tag[inv_idx];
                wb_accessed    <= ent_pte[inv_idx][B_ACC];
                wb_dirty       <= ent_pte[inv_idx][B_DIRTY];
            end
            if (fill_go) begin
                ent_v[vic_idx]   <= 1'b1;
                ent_tag[vic_idx] <= miss_va[VA_W-1:OFF_W];
                ent_pte[vic_idx] <= rf_pte;
                if (vic_evict) begin
                    wb_valid    <= 1'b1;
                    wb_vpn      <= ent_tag[vic_idx];
                    wb_accessed <= ent_pte[vic_idx][B_ACC];
                    wb_dirty    <= ent_pte[vic_idx][B_DIRTY];
                end
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_paddr,
    input logic        rf_req,
    input logic [31:0] rf_vaddr,
    input logic        rf_valid,
    input logic        inv_valid,
    input logic        wb_valid
);
    AST_RSP_FROM_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && lk_ready)); // R2
    AST_HIT_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_cause == 2'd0 && !rsp_fault); // R2
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_cause != 2'd0 && rsp_paddr == 32'd0); // R4
    AST_MISS_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit && !rsp_fault |-> rf_req); // R3
    AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req && !rf_valid |=> rf_req && $stable(rf_vaddr)); // R3
    AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> !lk_ready); // R3
    AST_WB_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(rf_req && rf_valid) || $past(inv_valid)); // R8
    AST_INV_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_valid) |-> !rsp_valid); // R10
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    localparam int CLK_NS = 10;
    localparam int K_MISS = 0, K_HIT = 1, K_FAULT = 2;

    logic clk = 0, rst_n = 0;
    logic lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [31:0] lk_vaddr = 0;
    logic lk_ready, rsp_valid, rsp_hit, rsp_fault;
    logic [1:0] rsp_cause;
    logic [31:0] rsp_paddr, rf_vaddr;
    logic rf_req, rf_valid = 0;
    logic [31:0] rf_pte = 0;
    logic inv_valid = 0;
    logic [19:0] inv_vpn = 0;
    logic wb_valid, wb_accessed, wb_dirty;
    logic [19:0] wb_vpn;

    int n_chk = 0, n_bad = 0;

    typedef struct {
        int          kind;
        logic [1:0]  cause;
        logic [31:0] pa;
        string       rq;
    } exp_t;
    exp_t sb[$];

    tlb_xlate u0 (.*);

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, got, exp);
        end
    endtask

    // monitor: pops expected results as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R2 unexpected response", {31'd0, rsp_valid}, 64'd0);
            end else begin
                exp_t e;
                logic [35:0] g, x;
                e = sb.pop_front();
                g = {rsp_hit, rsp_fault, rsp_cause, rsp_paddr};
                x = {e.kind == K_HIT, e.kind == K_FAULT, e.cause, e.pa};
                chk(g == x, e.rq, {28'd0, g}, {28'd0, x});
            end
        end
    end

    task automatic lookup(input [31:0] va, input bit wr, input bit us,
                          input int kind, input [1:0] cause, input [31:0] pa, input string rq);
        exp_t e;
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = us;
        e.kind = kind; e.cause = cause; e.pa = pa; e.rq = rq;
        sb.push_back(e);
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic do_miss(input [31:0] va, input bit wr, input bit us, input [31:0] pte,
                           input bit inv_during, input [19:0] ivpn,
                           output bit wbv, output logic [19:0] wvpn);
        lookup(va, wr, us, K_MISS, 2'd0, 32'd0, "R3 miss");
        chk(rf_req == 1 && rf_vaddr == va, "R3 request held", {31'd0, rf_req, rf_vaddr}, {31'd0, 1'b1, va});
        chk(lk_ready == 0, "R3 ready low", {63'd0, lk_ready}, 64'd0);
        if (inv_during) begin
            inv_valid = 1; inv_vpn = ivpn;
            @(negedge clk);
            inv_valid = 0;
            @(negedge clk);
            chk(wb_valid == 0, "R10 inv ignored in fill", {63'd0, wb_valid}, 64'd0);
        end
        rf_valid = 1; rf_pte = pte;
        @(negedge clk);
        rf_valid = 0;
        wbv = wb_valid; wvpn = wb_vpn;
        chk(rf_req == 0, "R3 request dropped", {63'd0, rf_req}, 64'd0);
    endtask

    task automatic invalidate(input [19:0] vpn, input bit with_lk,
                              output bit wbv, output logic [19:0] wvpn, output bit a, output bit d);
        @(negedge clk);
        inv_valid = 1; inv_vpn = vpn;
        if (with_lk) begin
            lk_valid = 1; lk_vaddr = 32'h0040_1000; lk_write = 0; lk_user = 0;
            #1;
            chk(lk_ready == 0, "R10 ready low on inv", {63'd0, lk_ready}, 64'd0);
        end
        @(negedge clk);
        inv_valid = 0; lk_valid = 0;
        wbv = wb_valid; wvpn = wb_vpn; a = wb_accessed; d = wb_dirty;
        if (with_lk) chk(rsp_valid == 0, "R10 no response", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit wbv, a, d, found;
        logic [19:0] wvpn;
        logic [19:0] loaded[$];

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 0 && rf_req == 0 && wb_valid == 0 && lk_ready == 1, "R1 reset state",
            {60'd0, rsp_valid, rf_req, wb_valid, lk_ready}, 64'd1);

        // R1 R2 R3: cold miss, refill, 4 KiB translation
        do_miss(32'h0040_1123, 0, 1, 32'h1234_5007, 0, 0, wbv, wvpn);
        chk(wbv == 0, "R9 free slot no writeback", {63'd0, wbv}, 64'd0);
        lookup(32'h0040_1123, 0, 1, K_HIT, 2'd0, 32'h1234_5123, "R2 read hit");
        lookup(32'h0040_1FF0, 1, 1, K_HIT, 2'd0, 32'h1234_5FF0, "R2 write hit");
        // R6 R8: accessed and dirty come out on invalidate
        invalidate(20'h00401, 1, wbv, wvpn, a, d);
        chk({wbv, wvpn, a, d} == {1'b1, 20'h00401, 1'b1, 1'b1}, "R8 R6 inv writeback",
            {41'd0, wbv, wvpn, a, d}, {41'd0, 1'b1, 20'h00401, 1'b1, 1'b1});
        invalidate(20'h7777_7, 0, wbv, wvpn, a, d);
        chk(wbv == 0, "R8 no match no writeback", {63'd0, wbv}, 64'd0);
        do_miss(32'h0040_1123, 0, 1, 32'h1234_5007, 0, 0, wbv, wvpn);
        loaded.push_back(20'h00401);

        // R4 R5: not present beats everything
        do_miss(32'h0080_2000, 0, 0, 32'h0000_0000, 0, 0, wbv, wvpn);
        loaded.push_back(20'h00802);
        lookup(32'h0080_2010, 1, 1, K_FAULT, 2'd1, 32'd0, "R4 not present");

        // R5: write protect
        do_miss(32'h00C0_3000, 0, 1, 32'h2222_2005, 0, 0, wbv, wvpn);
        loaded.push_back(20'h00C03);
        lookup(32'h00C0_3010, 0, 1, K_HIT, 2'd0, 32'h2222_2010, "R5 read of ro page");
        lookup(32'h00C0_3010, 1, 1, K_FAULT, 2'd2, 32'd0, "R5 write protect");

        // R5 R6: user protect, fault leaves accessed clear
        do_miss(32'h0100_4000, 0, 1, 32'h3333_3003, 0, 0, wbv, wvpn);
        lookup(32'h0100_4ABC, 0, 1, K_FAULT, 2'd3, 32'd0, "R5 user protect");
        invalidate(20'h01004, 0, wbv, wvpn, a, d);
        chk({wbv, a, d} == 3'b100, "R6 fault sets no status", {61'd0, wbv, a, d}, 64'd4);
        // R10: invalidate while refill outstanding is ignored
        do_miss(32'h0100_4000, 0, 0, 32'h3333_3003, 1, 20'h00C03, wbv, wvpn);
        loaded.push_back(20'h01004);
        lookup(32'h0100_4ABC, 0, 0, K_HIT, 2'd0, 32'h3333_3ABC, "R5 supervisor ok");
        lookup(32'h00C0_3020, 0, 0, K_HIT, 2'd0, 32'h2222_2020, "R10 entry survived");

        // R7: large page
        do_miss(32'h0BC1_2345, 0, 1, 32'h0C00_0087, 0, 0, wbv, wvpn);
        loaded.push_back(20'h0BC12);
        lookup(32'h0BC1_2345, 0, 1, K_HIT, 2'd0, 32'h0C01_2345, "R7 large hit");
        lookup(32'h0BFF_FFF0, 1, 1, K_HIT, 2'd0, 32'h0C3F_FFF0, "R7 large far offset");

        // R9: fill remaining slots, then evict
        for (int k = 0; k < 3; k++) begin
            do_miss({20'h20000 + 20'(k), 12'h000}, 0, 0, 32'h4444_4001, 0, 0, wbv, wvpn);
            loaded.push_back(20'h20000 + 20'(k));
            chk(wbv == 0, "R9 free slot first", {63'd0, wbv}, 64'd0);
        end
        lookup(32'h2000_0008, 1, 1, K_FAULT, 2'd3, 32'd0, "R5 user before write");
        lookup(32'h2000_0008, 1, 0, K_FAULT, 2'd2, 32'd0, "R5 supervisor write");
        do_miss(32'h3000_0000, 0, 0, 32'h5555_5001, 0, 0, wbv, wvpn);
        found = 0;
        foreach (loaded[i]) if (loaded[i] == wvpn) found = 1;
        chk(wbv == 1 && found, "R9 eviction writeback", {43'd0, wbv, wvpn}, {43'd0, 1'b1, wvpn});
        do_miss({wvpn, 12'h000}, 0, 0, 32'h6666_6001, 0, 0, wbv, wvpn);
        chk(wbv == 1, "R9 full refill evicts", {63'd0, wbv}, 64'd1);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2 all responses seen", 64'(sb.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule